// File: doc/BRIEF.md
# Span Z and Colour Interpolator

This block walks one horizontal span of a rasterised polygon and produces one pixel per clock. For every pixel it delivers a frame-buffer address, an interpolated depth value and interpolated red, green and blue values. Each of these is a running fixed-point value that a per-pixel slope is added to at every step. A signed span count sets both the number of pixels and the direction the address moves in.

The block also decides whether each pixel is written. The new depth is compared with the stored depth, which arrives on a read-data input for the address currently shown. The result is then gated by a 16-bit screen-door transparency pattern. Control inputs choose a narrow or wide depth format, freeze depth or colour, hold the address fixed, or blank red and green for pseudo-colour output. All values and controls are captured when the span starts.

Top module: `span_interp`

## Requirements
- R1: After reset `px_valid`, `px_we` and `done` are low.
- R2: A `start` pulse seen while idle begins a span of |`span_cnt`| pixels. `span_cnt` is 13-bit two's complement, and one pixel is shown per clock from the cycle after `start`. The address begins at `addr_start` and moves by +1 per pixel for a positive count or by -1 for a negative count, wrapping modulo 2^24.
- R3: Depth is unsigned fixed point with 12 fraction bits. With `prec24` low it has 16 integer bits and the running value wraps modulo 2^28. With `prec24` high it has 24 integer bits and wraps modulo 2^36. Pixel k shows the integer part of `z_start + k*z_slope`, where `z_slope` is the two's complement of the same width.
- R4: Red, green and blue are 8.12 fixed point with two's-complement slopes and wrap modulo 2^20. Pixel k shows the integer part of `start + k*slope` for each channel.
- R5: `cmp_en` bit 2 enables new<old, bit 1 enables new>old and bit 0 enables new==old. These compare integer depth against `z_old`, using only `z_old[15:0]` in the narrow format. A pixel can be written only if an enabled comparison is true.
- R6: Pixel k is suppressed (`px_we` low) when bit (k mod 16) of `sd_mask` is 1.
- R7: With `z_off` set the depth stays at its start value for the whole span. With `c_off` set all three colours stay at their start values.
- R8: With `pseudo` set `px_r` and `px_g` are zero while `px_b` carries the blue value.
- R9: With `addr_fix` set every pixel of the span shows `addr_start`.
- R10: `done` is high for exactly the one cycle after the last pixel. A span count of zero shows no pixel and raises `done` in the cycle after `start`.
- R11: A `start` pulse during a span is ignored.
- R12: Changes to the value, slope and control inputs after `start` do not affect the running span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a span (accepted when idle) |
| span_cnt | input | 13 | Signed pixel count; sign selects direction |
| addr_start | input | 24 | Address of the first pixel |
| z_start | input | 36 | Start depth, 24.12 (narrow format uses low 28 bits) |
| z_slope | input | 36 | Per-pixel depth increment |
| r_start | input | 20 | Start red, 8.12 |
| r_slope | input | 20 | Per-pixel red increment |
| g_start | input | 20 | Start green, 8.12 |
| g_slope | input | 20 | Per-pixel green increment |
| b_start | input | 20 | Start blue, 8.12 |
| b_slope | input | 20 | Per-pixel blue increment |
| prec24 | input | 1 | Wide depth format |
| z_off | input | 1 | Freeze depth |
| c_off | input | 1 | Freeze colour |
| addr_fix | input | 1 | Hold address |
| pseudo | input | 1 | Blank red and green |
| cmp_en | input | 3 | Depth-test enables: less, greater, equal |
| sd_mask | input | 16 | Screen-door pattern, 1 = suppress |
| z_old | input | 24 | Stored depth at `px_addr` |
| px_valid | output | 1 | A pixel is shown this cycle |
| px_addr | output | 24 | Pixel address |
| px_z | output | 24 | Integer depth |
| px_r | output | 8 | Integer red |
| px_g | output | 8 | Integer green |
| px_b | output | 8 | Integer blue |
| px_we | output | 1 | Write the pixel |
| done | output | 1 | Span finished |

## Verification
The hardest situation to reach is a `start` that arrives in the middle of a running span while every data and control input changes at the same moment. The design must ignore the pulse and keep using its captured copies. The stimulus drives such a pulse two pixels into a span and, in the same cycle, changes the start values, slopes, count, format and pseudo-colour bit. It then checks every remaining pixel against expectations computed from the values captured at the original start. Depth wrap in the narrow format and the recycling of the 16-bit mask index both need spans built for the purpose: one starts depth just below 2^16, and another runs 20 pixels.

// File: rtl/span_interp_pkg.sv
package span_interp_pkg;

    // Bit positions inside the depth-test enable field
    localparam int CMP_LT = 2;
    localparam int CMP_GT = 1;
    localparam int CMP_EQ = 0;

    // Controls captured when a span is accepted
    typedef struct packed {
        logic       prec24;
        logic       z_off;
        logic       c_off;
        logic       a_fix;
        logic       pseudo;
        logic [2:0] cmp_en;
    } span_ctl_t;

    localparam int NUM_CH = 3;
    localparam int CH_R   = 0;
    localparam int CH_G   = 1;
    localparam int CH_B   = 2;

endpackage

// File: rtl/span_seq.sv
module span_seq #(
    parameter int CNT_W  = 13,
    parameter int ADDR_W = 24,
    parameter int POS_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  span_cnt,
    input  logic [ADDR_W-1:0] addr_start,
    input  logic              addr_fix,
    output logic              busy,
    output logic              load,
    output logic [ADDR_W-1:0] addr,
    output logic [POS_W-1:0]  pos,
    output logic              done
);
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] mag;
    logic             dir_down;

    assign mag  = span_cnt[CNT_W-1] ? (~span_cnt + CNT_W'(1)) : span_cnt;
    assign load = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            remain   <= '0;
            addr     <= '0;
            pos      <= '0;
            dir_down <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                addr     <= addr_start;
                pos      <= '0;
                dir_down <= span_cnt[CNT_W-1];
                remain   <= mag;
                busy     <= (mag != '0);
                done     <= (mag == '0);
            end else if (busy) begin
                pos    <= pos + POS_W'(1);
                remain <= remain - CNT_W'(1);
                if (!addr_fix) begin
                    addr <= dir_down ? addr - ADDR_W'(1) : addr + ADDR_W'(1);
                end
                if (remain == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/span_acc.sv
module span_acc #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         hold,
    input  logic [W-1:0] init,
    input  logic [W-1:0] slope,
    input  logic [W-1:0] keep,
    output logic [W-1:0] val
);
    logic [W-1:0] slope_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val     <= '0;
            slope_q <= '0;
        end else if (load) begin
            val     <= init & keep;
            slope_q <= slope;
        end else if (step && !hold) begin
            val <= (val + slope_q) & keep;
        end
    end
endmodule

// File: rtl/span_wgate.sv
module span_wgate #(
    parameter int ZI_W   = 24,
    parameter int ZI_NAR = 16,
    parameter int MASK_W = 16,
    parameter int POS_W  = 4
) (
    input  logic              valid,
    input  logic [POS_W-1:0]  pos,
    input  logic [MASK_W-1:0] mask,
    input  logic [2:0]        cmp_en,
    input  logic              wide,
    input  logic [ZI_W-1:0]   z_new,
    input  logic [ZI_W-1:0]   z_old,
    output logic              we
);
    import span_interp_pkg::*;

    logic [ZI_W-1:0] old_eff;
    logic            test_ok;

    assign old_eff = wide ? z_old : {{(ZI_W-ZI_NAR){1'b0}}, z_old[ZI_NAR-1:0]};

    always_comb begin
        test_ok = (cmp_en[CMP_LT] && (z_new <  old_eff)) ||
                  (cmp_en[CMP_GT] && (z_new >  old_eff)) ||
                  (cmp_en[CMP_EQ] && (z_new == old_eff));
    end

    assign we = valid && !mask[pos] && test_ok;
endmodule

// File: rtl/span_interp.sv
module span_interp #(
    parameter int CNT_W  = 13,
    parameter int ADDR_W = 24,
    parameter int ZI_W   = 24,
    parameter int ZI_NAR = 16,
    parameter int FR_W   = 12,
    parameter int CI_W   = 8,
    parameter int MASK_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [CNT_W-1:0]       span_cnt,
    input  logic [ADDR_W-1:0]      addr_start,
    input  logic [ZI_W+FR_W-1:0]   z_start,
    input  logic [ZI_W+FR_W-1:0]   z_slope,
    input  logic [CI_W+FR_W-1:0]   r_start,
    input  logic [CI_W+FR_W-1:0]   r_slope,
    input  logic [CI_W+FR_W-1:0]   g_start,
    input  logic [CI_W+FR_W-1:0]   g_slope,
    input  logic [CI_W+FR_W-1:0]   b_start,
    input  logic [CI_W+FR_W-1:0]   b_slope,
    input  logic                   prec24,
    input  logic                   z_off,
    input  logic                   c_off,
    input  logic                   addr_fix,
    input  logic                   pseudo,
    input  logic [2:0]             cmp_en,
    input  logic [MASK_W-1:0]      sd_mask,
    input  logic [ZI_W-1:0]        z_old,
    output logic                   px_valid,
    output logic [ADDR_W-1:0]      px_addr,
    output logic [ZI_W-1:0]        px_z,
    output logic [CI_W-1:0]        px_r,
    output logic [CI_W-1:0]        px_g,
    output logic [CI_W-1:0]        px_b,
    output logic                   px_we,
    output logic                   done
);
    import span_interp_pkg::*;

    localparam int Z_W   = ZI_W + FR_W;
    localparam int C_W   = CI_W + FR_W;
    localparam int POS_W = $clog2(MASK_W);
    localparam logic [Z_W-1:0] Z_KEEP_NAR = {{(ZI_W-ZI_NAR){1'b0}}, {(ZI_NAR+FR_W){1'b1}}};

    span_ctl_t         ctl_q;
    logic [MASK_W-1:0] mask_q;
    logic              busy;
    logic              load;
    logic [POS_W-1:0]  pix_pos;
    logic [Z_W-1:0]    z_val;
    logic [Z_W-1:0]    z_keep;
    logic              keep_wide;

    // Captured controls
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            ctl_q  <= '{prec24: prec24, z_off: z_off, c_off: c_off,
                        a_fix: addr_fix, pseudo: pseudo, cmp_en: cmp_en};
            mask_q <= sd_mask;
        end
    end

    span_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .POS_W(POS_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .span_cnt   (span_cnt),
        .addr_start (addr_start),
        .addr_fix   (ctl_q.a_fix),
        .busy       (busy),
        .load       (load),
        .addr       (px_addr),
        .pos        (pix_pos),
        .done       (done)
    );

    // Depth accumulator: format comes from the input while loading, else from the copy
    assign keep_wide = load ? prec24 : ctl_q.prec24;
    assign z_keep    = keep_wide ? '1 : Z_KEEP_NAR;

    span_acc #(.W(Z_W)) u_zacc (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .step  (busy),
        .hold  (ctl_q.z_off),
        .init  (z_start),
        .slope (z_slope),
        .keep  (z_keep),
        .val   (z_val)
    );

    // Colour accumulators
    logic [C_W-1:0]  c_init  [NUM_CH];
    logic [C_W-1:0]  c_slope [NUM_CH];
    logic [C_W-1:0]  c_val   [NUM_CH];
    logic [CI_W-1:0] c_int   [NUM_CH];

    assign c_init[CH_R]  = r_start;
    assign c_init[CH_G]  = g_start;
    assign c_init[CH_B]  = b_start;
    assign c_slope[CH_R] = r_slope;
    assign c_slope[CH_G] = g_slope;
    assign c_slope[CH_B] = b_slope;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        span_acc #(.W(C_W)) u_cacc (
            .clk   (clk),
            .rst   (rst),
            .load  (load),
            .step  (busy),
            .hold  (ctl_q.c_off),
            .init  (c_init[ch]),
            .slope (c_slope[ch]),
            .keep  ('1),
            .val   (c_val[ch])
        );
        assign c_int[ch] = c_val[ch][C_W-1:FR_W];
    end

    assign px_valid = busy;
    assign px_z     = z_val[Z_W-1:FR_W];
    assign px_r     = ctl_q.pseudo ? '0 : c_int[CH_R];
    assign px_g     = ctl_q.pseudo ? '0 : c_int[CH_G];
    assign px_b     = c_int[CH_B];

    span_wgate #(.ZI_W(ZI_W), .ZI_NAR(ZI_NAR), .MASK_W(MASK_W), .POS_W(POS_W)) u_wgate (
        .valid  (busy),
        .pos    (pix_pos),
        .mask   (mask_q),
        .cmp_en (ctl_q.cmp_en),
        .wide   (ctl_q.prec24),
        .z_new  (px_z),
        .z_old  (z_old),
        .we     (px_we)
    );
endmodule

// File: rtl/span_interp_chk.sv
module span_interp_chk #(
    parameter int ADDR_W = 24,
    parameter int ZI_W   = 24,
    parameter int CI_W   = 8,
    parameter int MASK_W = 16,
    parameter int POS_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              px_valid,
    input logic              px_we,
    input logic              done,
    input logic [ADDR_W-1:0] px_addr,
    input logic [ZI_W-1:0]   px_z,
    input logic [CI_W-1:0]   px_r,
    input logic [CI_W-1:0]   px_g,
    input logic [CI_W-1:0]   px_b,
    input logic [POS_W-1:0]  pos,
    input logic [MASK_W-1:0] mask,
    input logic              z_off,
    input logic              c_off,
    input logic              a_fix,
    input logic              pseudo
);
    a_r2_we_needs_pixel: assert property (@(posedge clk) disable iff (rst)
        !px_valid |-> !px_we);

    a_r6_mask_suppresses: assert property (@(posedge clk) disable iff (rst)
        (px_valid && mask[pos]) |-> !px_we);

    a_r7_z_frozen: assert property (@(posedge clk) disable iff (rst)
        (px_valid && $past(px_valid) && z_off) |-> $stable(px_z));

    a_r7_colour_frozen: assert property (@(posedge clk) disable iff (rst)
        (px_valid && $past(px_valid) && c_off) |-> ($stable(px_r) && $stable(px_g) && $stable(px_b)));

    a_r8_pseudo_blank: assert property (@(posedge clk) disable iff (rst)
        (px_valid && pseudo) |-> (px_r == '0 && px_g == '0));

    a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
        (px_valid && $past(px_valid) && a_fix) |-> $stable(px_addr));

    a_r10_done_no_pixel: assert property (@(posedge clk) disable iff (rst)
        done |-> !px_valid);

    a_r10_done_after_last: assert property (@(posedge clk) disable iff (rst)
        ($fell(px_valid)) |-> done);
endmodule

bind span_interp span_interp_chk #(
    .ADDR_W(ADDR_W), .ZI_W(ZI_W), .CI_W(CI_W), .MASK_W(MASK_W), .POS_W(POS_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .px_valid (px_valid),
    .px_we    (px_we),
    .done     (done),
    .px_addr  (px_addr),
    .px_z     (px_z),
    .px_r     (px_r),
    .px_g     (px_g),
    .px_b     (px_b),
    .pos      (pix_pos),
    .mask     (mask_q),
    .z_off    (ctl_q.z_off),
    .c_off    (ctl_q.c_off),
    .a_fix    (ctl_q.a_fix),
    .pseudo   (ctl_q.pseudo)
);

// File: tb/span_interp_tb.sv
module span_interp_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [12:0] span_cnt = '0;
    logic [23:0] addr_start = '0;
    logic [35:0] z_start = '0, z_slope = '0;
    logic [19:0] r_start = '0, r_slope = '0, g_start = '0, g_slope = '0, b_start = '0, b_slope = '0;
    logic        prec24 = 1'b0, z_off = 1'b0, c_off = 1'b0, addr_fix = 1'b0, pseudo = 1'b0;
    logic [2:0]  cmp_en = '0;
    logic [15:0] sd_mask = '0;
    logic [23:0] z_old = '0;
    logic        px_valid, px_we, done;
    logic [23:0] px_addr, px_z;
    logic [7:0]  px_r, px_g, px_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    span_interp u_dut (
        .clk(clk), .rst(rst), .start(start), .span_cnt(span_cnt), .addr_start(addr_start),
        .z_start(z_start), .z_slope(z_slope), .r_start(r_start), .r_slope(r_slope),
        .g_start(g_start), .g_slope(g_slope), .b_start(b_start), .b_slope(b_slope),
        .prec24(prec24), .z_off(z_off), .c_off(c_off), .addr_fix(addr_fix), .pseudo(pseudo),
        .cmp_en(cmp_en), .sd_mask(sd_mask), .z_old(z_old),
        .px_valid(px_valid), .px_addr(px_addr), .px_z(px_z), .px_r(px_r), .px_g(px_g),
        .px_b(px_b), .px_we(px_we), .done(done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cexp(input logic [19:0] s, input logic [19:0] sl, input int k);
        logic [19:0] v;
        v = s + 20'(k) * sl;
        return v[19:12];
    endfunction

    // Drives one span and checks every pixel against values captured at start
    task automatic run_span(input string name, input bit inject);
        logic [35:0] s_zs = z_start, s_zsl = z_slope, v;
        logic [19:0] s_cs[3], s_csl[3];
        logic [12:0] s_cnt = span_cnt;
        logic [23:0] s_a0 = addr_start, zi, oe, ea;
        logic        s_p24 = prec24, s_zo = z_off, s_co = c_off, s_af = addr_fix, s_ps = pseudo;
        logic [2:0]  s_cmp = cmp_en;
        logic [15:0] s_m = sd_mask;
        logic        ew;
        int n, kz, kc;
        s_cs[0] = r_start; s_cs[1] = g_start; s_cs[2] = b_start;
        s_csl[0] = r_slope; s_csl[1] = g_slope; s_csl[2] = b_slope;
        n = s_cnt[12] ? int'(13'(~s_cnt + 13'd1)) : int'(s_cnt);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (n == 0) begin
            chk({name, " R10 zero count no pixel"}, 64'(px_valid), 64'd0);
            chk({name, " R10 zero count done"}, 64'(done), 64'd1);
            @(negedge clk);
            chk({name, " R10 done one cycle"}, 64'(done), 64'd0);
            return;
        end
        for (int k = 0; k < n; k++) begin
            kz = s_zo ? 0 : k;
            kc = s_co ? 0 : k;
            v  = s_zs + 36'(kz) * s_zsl;
            if (!s_p24) v[35:28] = '0;
            zi = v[35:12];
            oe = s_p24 ? z_old : {8'd0, z_old[15:0]};
            ew = !s_m[k % 16] && ((s_cmp[2] && zi < oe) || (s_cmp[1] && zi > oe) || (s_cmp[0] && zi == oe));
            ea = s_af ? s_a0 : (s_cnt[12] ? s_a0 - 24'(k) : s_a0 + 24'(k));
            chk({name, " R2 valid"}, 64'(px_valid), 64'd1);
            chk({name, " R2 R9 addr"}, 64'(px_addr), 64'(ea));
            chk({name, " R3 R7 z"}, 64'(px_z), 64'(zi));
            chk({name, " R4 R8 red"}, 64'(px_r), s_ps ? 64'd0 : 64'(cexp(s_cs[0], s_csl[0], kc)));
            chk({name, " R4 R8 green"}, 64'(px_g), s_ps ? 64'd0 : 64'(cexp(s_cs[1], s_csl[1], kc)));
            chk({name, " R4 blue"}, 64'(px_b), 64'(cexp(s_cs[2], s_csl[2], kc)));
            chk({name, " R5 R6 we"}, 64'(px_we), 64'(ew));
            chk({name, " R10 no early done"}, 64'(done), 64'd0);
            if (inject && k == 1) begin
                // R11 R12: start while busy, with every input changed
                start = 1'b1; span_cnt = 13'd2; addr_start = 24'h777777;
                z_start = 36'h123456789; z_slope = 36'h000005000;
                r_start = 20'hFFFFF; r_slope = 20'h11111; g_slope = 20'h22222; b_slope = 20'h33333;
                prec24 = ~prec24; pseudo = ~pseudo; addr_fix = ~addr_fix; z_off = ~z_off;
                c_off = ~c_off; cmp_en = ~cmp_en; sd_mask = ~sd_mask;
            end
            if (inject && k == 2) start = 1'b0;
            @(negedge clk);
        end
        chk({name, " R10 done after last"}, 64'(done), 64'd1);
        chk({name, " R10 no pixel at done"}, 64'(px_valid), 64'd0);
        @(negedge clk);
        chk({name, " R10 done one cycle"}, 64'(done), 64'd0);
    endtask

    task automatic defaults();
        prec24 = 0; z_off = 0; c_off = 0; addr_fix = 0; pseudo = 0;
        cmp_en = 3'b111; sd_mask = '0; z_old = 24'h00FFFF;
        z_start = 36'h000100800; z_slope = 36'h000001800;
        r_start = 20'h10000; r_slope = 20'h00800;
        g_start = 20'h80000; g_slope = 20'hFF800;
        b_start = 20'h20000; b_slope = 20'h02400;
        addr_start = 24'h001000; span_cnt = 13'd5;
    endtask

    task automatic t_reset();
        chk("R1 valid after reset", 64'(px_valid), 64'd0);
        chk("R1 we after reset", 64'(px_we), 64'd0);
        chk("R1 done after reset", 64'(done), 64'd0);
    endtask

    task automatic t_basic();
        defaults(); cmp_en = 3'b100;
        run_span("basic forward", 0);
    endtask

    task automatic t_backward_wrap();
        defaults(); span_cnt = 13'h1FFC; addr_start = 24'h000002;
        z_start = 36'h00FFFF000; z_slope = 36'h000001000;
        run_span("backward narrow wrap", 0);
    endtask

    task automatic t_wide();
        defaults(); prec24 = 1; cmp_en = 3'b010; span_cnt = 13'd3;
        z_start = 36'h00FFFF000; z_slope = 36'h000001000;
        run_span("wide up", 0);
        defaults(); prec24 = 1; span_cnt = 13'd3; z_old = 24'h800000;
        z_start = 36'h000000800; z_slope = 36'hFFFFFF000;
        run_span("wide negative slope", 0);
    endtask

    task automatic t_compare();
        for (int c = 0; c < 8; c++) begin
            defaults(); cmp_en = 3'(c); z_old = 24'h000102;
            z_start = 36'h000100000; z_slope = 36'h000001000;
            run_span($sformatf("compare %0d", c), 0);
        end
    endtask

    task automatic t_mask();
        defaults(); span_cnt = 13'd20; sd_mask = 16'hA5C3;
        run_span("screen door", 0);
    endtask

    task automatic t_freeze();
        defaults(); z_off = 1;
        run_span("depth frozen", 0);
        defaults(); c_off = 1;
        run_span("colour frozen", 0);
    endtask

    task automatic t_pseudo();
        defaults(); pseudo = 1;
        run_span("pseudo colour", 0);
    endtask

    task automatic t_addr_fix();
        defaults(); addr_fix = 1; span_cnt = 13'h1FFA;
        run_span("address held", 0);
    endtask

    task automatic t_zero();
        defaults(); span_cnt = 13'd0;
        run_span("zero span", 0);
    endtask

    task automatic t_busy_start();
        defaults(); span_cnt = 13'd6; sd_mask = 16'h0005;
        run_span("start while busy", 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_backward_wrap();
        t_wide();
        t_compare();
        t_mask();
        t_freeze();
        t_pseudo();
        t_addr_fix();
        t_zero();
        t_busy_start();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule